// File: doc/BRIEF.md
# Stereo Resampler History Buffer

This block keeps the recent history of a two-channel audio stream for the interpolation filter of a sample rate converter. Every input-rate strobe stores one left and one right sample. The two samples go into two separate memories at the position held by a wrapping write counter. The read side runs at the output rate. Each request fetches one filter tap from both channels at once, and the data comes back one cycle later.

The read position is measured backwards from a reference that trails the write counter by a fixed guard distance. Within that distance the newest samples are never read, so a normal window of taps cannot land on the word being written in the same cycle. The read side supplies a phase base, which sets how deep into the history the window starts, and a tap index within the window. A request whose window would reach all the way round to the write position raises an overrun flag next to its data. The guard distance, the window length and the memory depth together set the largest decimation ratio the converter can sustain.

Top module: `stereo_hist_buf`

## Requirements
- R1: After reset the write counter is zero, `rd_valid` and `overrun` are low, and both data outputs are zero.
- R2: Each cycle with `in_strobe` high stores `in_left` and `in_right` at the write counter. The counter then advances by one, modulo the depth of 512.
- R3: A request reads the address (W − 16 − 1 − tap − phase) mod 512, where W is the write counter before the request edge. With tap 0 and phase 0, this returns the sample stored 17 strobes earlier.
- R4: Data requested at one rising edge appears on `rd_left`/`rd_right` after the next rising edge. `rd_valid` is high for exactly the one cycle after each request.
- R5: A location that has not been written since reset reads as zero.
- R6: `overrun` is high together with `rd_valid` when phase + 64 ≥ 512 − 16, that is when phase ≥ 432, and is low otherwise.
- R7: The left and right channels are stored in separate memories. Each output returns only its own channel's sample.
- R8: After more than 512 strobes the write position wraps. Newer samples replace the oldest ones, and reads follow the wrapped addresses.
- R9: Between requests the data outputs keep their last value, whatever happens on the other inputs.
- R10: When a read and a strobe target the same word in the same cycle, the read returns the word's content from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| in_strobe | input | 1 | Input-rate sample strobe |
| in_left | input | 24 | Left input sample |
| in_right | input | 24 | Right input sample |
| rd_req | input | 1 | Tap fetch request |
| tap_idx | input | 6 | Tap index within the window |
| phase_base | input | 9 | Window start depth set by the read side |
| rd_left | output | 24 | Left tap data |
| rd_right | output | 24 | Right tap data |
| rd_valid | output | 1 | Tap data valid, one cycle after the request |
| overrun | output | 1 | Requested window reaches the guarded write region |

## Verification
Reads are first made into an empty buffer, which shows the zero fill of unwritten words. They are then made after a partial fill, with tap and phase varied separately, so that an error in one address term cannot be hidden by the other. Left and right carry unrelated sample patterns, which would expose any swap or sharing of the two memories. A long run of strobes past the memory size exercises the address wrap. Reads issued on strobe cycles show both the write-counter value that the address uses and the read-before-write ordering. The overrun limit is probed at phase 431 and 432.

// File: rtl/hist_pkg.sv
package hist_pkg;
    // channel slots of the stereo memory pair
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/hist_addr_gen.sv
module hist_addr_gen #(
    parameter int DEPTH = 512,
    parameter int GUARD = 16,
    parameter int TAPS  = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int TW   = $clog2(TAPS)
) (
    input  logic [AW-1:0] wp,
    input  logic [TW-1:0] tap,
    input  logic [AW-1:0] phase,
    output logic [AW-1:0] raddr,
    output logic          ovr_hit
);
    // reference point trails the write counter by the guard plus one
    localparam logic [AW-1:0] REF_LAG = AW'(GUARD + 1);
    // largest phase whose full window still stays clear of the guard
    localparam logic [AW-1:0] PH_LIM  = AW'(DEPTH - GUARD - TAPS - 1);

    logic [AW-1:0] tap_ext;

    always_comb begin
        tap_ext = {{(AW-TW){1'b0}}, tap};
        raddr   = wp - REF_LAG - tap_ext - phase;
        ovr_hit = (phase > PH_LIM);
    end
endmodule

// File: rtl/hist_ram.sv
module hist_ram #(
    parameter int DEPTH = 512,
    parameter int DW    = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    // read and write share the edge; the read sees the old word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/stereo_hist_buf.sv
module stereo_hist_buf
    import hist_pkg::*;
#(
    parameter int DW    = 24,
    parameter int DEPTH = 512,
    parameter int GUARD = 16,
    parameter int TAPS  = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int TW   = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_strobe,
    input  logic [DW-1:0] in_left,
    input  logic [DW-1:0] in_right,
    input  logic          rd_req,
    input  logic [TW-1:0] tap_idx,
    input  logic [AW-1:0] phase_base,
    output logic [DW-1:0] rd_left,
    output logic [DW-1:0] rd_right,
    output logic          rd_valid,
    output logic          overrun
);
    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [DEPTH-1:0] filled;
        logic             rd_vld;
        logic             ovr;
        logic             blank;
    } state_t;

    state_t st_d, st_q;

    logic [AW-1:0] wp_q;
    logic [AW-1:0] raddr;
    logic          ovr_hit;
    logic [DW-1:0] wdat [NUM_CH];
    logic [DW-1:0] rdat [NUM_CH];

    assign wp_q = st_q.wp;

    hist_addr_gen #(
        .DEPTH (DEPTH),
        .GUARD (GUARD),
        .TAPS  (TAPS)
    ) u_agen (
        .wp      (wp_q),
        .tap     (tap_idx),
        .phase   (phase_base),
        .raddr   (raddr),
        .ovr_hit (ovr_hit)
    );

    assign wdat[CH_LEFT]  = in_left;
    assign wdat[CH_RIGHT] = in_right;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        hist_ram #(
            .DEPTH (DEPTH),
            .DW    (DW)
        ) u_ram (
            .clk   (clk),
            .we    (in_strobe),
            .waddr (wp_q),
            .wdata (wdat[ch]),
            .re    (rd_req),
            .raddr (raddr),
            .rdata (rdat[ch])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.rd_vld = rd_req;
        st_d.ovr    = rd_req & ovr_hit;
        if (rd_req) begin
            // fill flag sampled before this edge's write: old content wins
            st_d.blank = ~st_q.filled[raddr];
        end
        if (in_strobe) begin
            st_d.filled[st_q.wp] = 1'b1;
            st_d.wp              = st_q.wp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wp     <= '0;
            st_q.filled <= '0;
            st_q.rd_vld <= 1'b0;
            st_q.ovr    <= 1'b0;
            st_q.blank  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_left  = st_q.blank ? '0 : rdat[CH_LEFT];
    assign rd_right = st_q.blank ? '0 : rdat[CH_RIGHT];
    assign rd_valid = st_q.rd_vld;
    assign overrun  = st_q.ovr;
endmodule

// File: rtl/hist_buf_chk.sv
module hist_buf_chk #(
    parameter int AW = 9,
    parameter int DW = 24,
    parameter int PH_LIM = 431
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_strobe,
    input logic          rd_req,
    input logic [AW-1:0] phase_base,
    input logic [AW-1:0] wp_q,
    input logic          rd_valid,
    input logic          overrun,
    input logic [DW-1:0] rd_left,
    input logic [DW-1:0] rd_right
);
    assert_wp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |=> wp_q == $past(wp_q) + 1'b1);

    assert_wp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_strobe |=> $stable(wp_q));

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_valid_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && int'(phase_base) > PH_LIM) |=> overrun);

    assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && int'(phase_base) <= PH_LIM) |=> !overrun);

    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> ($stable(rd_left) && $stable(rd_right)));
endmodule

bind stereo_hist_buf hist_buf_chk #(
    .AW     (AW),
    .DW     (DW),
    .PH_LIM (DEPTH - GUARD - TAPS - 1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_strobe  (in_strobe),
    .rd_req     (rd_req),
    .phase_base (phase_base),
    .wp_q       (wp_q),
    .rd_valid   (rd_valid),
    .overrun    (overrun),
    .rd_left    (rd_left),
    .rd_right   (rd_right)
);

// File: tb/sim_stereo_hist_buf.sv
`timescale 1ns/1ps
module sim_stereo_hist_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_strobe = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        rd_req = 1'b0;
    logic [5:0]  tap_idx = '0;
    logic [8:0]  phase_base = '0;
    logic [23:0] rd_left, rd_right;
    logic        rd_valid, overrun;

    int n_chk = 0;
    int n_err = 0;
    int cnt = 0;
    logic [23:0] ml [512];
    logic [23:0] mr [512];
    bit          mv [512];

    always #5 clk = ~clk;

    stereo_hist_buf u0 (
        .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe),
        .in_left(in_left), .in_right(in_right),
        .rd_req(rd_req), .tap_idx(tap_idx), .phase_base(phase_base),
        .rd_left(rd_left), .rd_right(rd_right),
        .rd_valid(rd_valid), .overrun(overrun)
    );

    function automatic logic [23:0] lval(input int i);
        return 24'h400000 ^ 24'(i * 3 + 1);
    endfunction

    function automatic logic [23:0] rval(input int i);
        return ~24'(i * 977 + 5);
    endfunction

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_write();
        ml[cnt & 511] = lval(cnt);
        mr[cnt & 511] = rval(cnt);
        mv[cnt & 511] = 1'b1;
        cnt++;
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_strobe = 1'b1;
            in_left   = lval(cnt);
            in_right  = rval(cnt);
            @(posedge clk);
            model_write();
        end
        @(negedge clk);
        in_strobe = 1'b0;
    endtask

    task automatic do_read(input string req, input int tap, input int ph, input bit stb);
        int a;
        logic [23:0] el, er;
        @(negedge clk);
        rd_req     = 1'b1;
        tap_idx    = 6'(tap);
        phase_base = 9'(ph);
        a  = (cnt - 17 - tap - ph) & 511;
        el = mv[a] ? ml[a] : 24'h0;
        er = mv[a] ? mr[a] : 24'h0;
        if (stb) begin
            in_strobe = 1'b1;
            in_left   = lval(cnt);
            in_right  = rval(cnt);
        end
        @(posedge clk);
        if (stb) model_write();
        @(negedge clk);
        rd_req    = 1'b0;
        in_strobe = 1'b0;
        check(req, "rd_valid", rd_valid, 1);
        check(req, "rd_left", rd_left, el);
        check(req, "rd_right", rd_right, er);
        check(req, "overrun", overrun, (ph >= 432) ? 1 : 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "rd_valid", rd_valid, 0);
        check("R1", "overrun", overrun, 0);
        check("R1", "rd_left", rd_left, 0);
        check("R1", "rd_right", rd_right, 0);
        do_read("R5", 0, 0, 0);
        do_read("R5", 40, 100, 0);
    endtask

    task automatic t_fill();
        write_n(100);
        // tap 0 phase 0 must return sample 100-17 = 83 (R3)
        check("R3", "model_idx83_left", ml[83], lval(83));
        do_read("R3", 0, 0, 0);
        do_read("R3", 5, 0, 0);
        do_read("R3", 0, 10, 0);
        do_read("R7", 7, 20, 0);
        do_read("R5", 30, 60, 0);
    endtask

    task automatic t_latency_hold();
        logic [23:0] hl, hr;
        do_read("R4", 3, 2, 0);
        hl = rd_left;
        hr = rd_right;
        @(negedge clk);
        tap_idx    = 6'd50;
        phase_base = 9'd5;
        in_strobe  = 1'b1;
        in_left    = lval(cnt);
        in_right   = rval(cnt);
        @(posedge clk);
        model_write();
        @(negedge clk);
        in_strobe = 1'b0;
        check("R4", "rd_valid_low", rd_valid, 0);
        check("R9", "rd_left_hold", rd_left, hl);
        check("R9", "rd_right_hold", rd_right, hr);
    endtask

    task automatic t_overrun();
        do_read("R6", 0, 431, 0);
        do_read("R6", 0, 432, 0);
        do_read("R6", 63, 511, 0);
    endtask

    task automatic t_wrap();
        write_n(600);
        do_read("R8", 0, 0, 0);
        do_read("R8", 63, 300, 0);
        do_read("R8", 12, 431, 0);
    endtask

    task automatic t_same_cycle();
        // read issued on a strobe edge uses the pre-strobe counter
        do_read("R2", 0, 0, 1);
        do_read("R2", 9, 3, 1);
        // lag 17+63+432 = 512 lands on the word being written: old data
        do_read("R10", 63, 432, 1);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mv[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_latency_hold();
        t_overrun();
        t_wrap();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule